// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves program-counter-relative control transfers for a small in-order core. Each cycle an instruction word, the address of that instruction and the four arithmetic status flags may be presented with a valid strobe. The unit recognises three kinds of relative transfer:

- conditional short branches with an 8-bit signed word offset,
- unconditional long branches with an 11-bit signed word offset,
- relative calls with an 11-bit signed word offset.

One cycle after the strobe it reports:

- the address to fetch next,
- whether the transfer was taken (the fetch stage uses this to flush the slot behind it),
- how many cycles the instruction occupies,
- for a call, a request to push the return address.

Addresses count bytes and every instruction is two bytes long. The sequential address is therefore PC+2, and a taken target is PC+2 plus twice the sign-extended offset, both wrapping modulo 2^PC_W. Any word that is not one of the three relative forms is treated as a non-branch: the unit reports the sequential address and a single cycle. The unit never alters the flags.

Top module: `relbr_unit`

## Requirements
- R1: While reset is asserted and after it is released with no valid input, out_valid, taken, push_req and is_branch are 0, next_pc and push_addr are 0, and cycles is 0.
- R2: The outputs for an input accepted with in_valid=1 appear exactly one clock later with out_valid=1. A cycle with in_valid=0 gives out_valid=0, taken=0 and push_req=0 one clock later.
- R3: A word with bits 15:11 = 11100 is a conditional branch, and bits 10:8 select the test: 000 Z set, 001 Z clear, 010 C set, 011 C clear, 100 OV set, 101 OV clear, 110 N set, 111 N clear.
- R4: A taken conditional branch gives next_pc = PC+2 + 2*sext(bits 7:0), so offsets 0x7F and 0x80 move by +254 and -256 bytes from PC+2.
- R5: A conditional branch whose test fails gives taken=0, next_pc = PC+2 and cycles=1. Its is_branch output is still 1.
- R6: Every taken transfer reports taken=1 and cycles=2.
- R7: A word with bits 15:11 = 11010 is an unconditional branch. It is taken whatever the flags hold, with next_pc = PC+2 + 2*sext(bits 10:0).
- R8: A word with bits 15:11 = 11011 is a relative call. It is taken with the same target rule as R7, and in the same output cycle it raises push_req with push_addr = PC+2.
- R9: Any other word, including bits 15:11 = 11101, 11110 and 11111, gives is_branch=0, taken=0, push_req=0, cycles=1 and next_pc = PC+2.
- R10: All address arithmetic wraps modulo 2^PC_W, in both the positive and the negative direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 16 | Instruction word |
| pc | input | PC_W | Byte address of the instruction |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_ov | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| out_valid | output | 1 | Result valid |
| is_branch | output | 1 | Word was a relative transfer |
| taken | output | 1 | Transfer taken; flush the following slot |
| next_pc | output | PC_W | Address to fetch next |
| cycles | output | 2 | Cycles the instruction occupies (1 or 2) |
| push_req | output | 1 | Push the return address |
| push_addr | output | PC_W | Return address to push |

## Verification
The bench walks all eight conditions with the selected flag both set and clear, while the other three flags hold the opposite value. A unit that decoded the wrong flag, or reversed the polarity bit, would therefore branch on the wrong cases. Offsets at both ends of the 8-bit and 11-bit ranges catch a missing sign extension, which would turn backward jumps into forward ones, and a missing doubling, which would land on odd word positions. Targets that cross the top and bottom of the address space catch arithmetic that does not wrap. Calls are checked for the push address and strobe, and the neighbouring words of the 1110 group for being ignored, so that a decoder matching too few opcode bits would show up as spurious branches.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COND = 2'd1,
    KIND_JUMP = 2'd2,
    KIND_CALL = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic c;
    logic z;
  } br_flags_t;

  localparam logic [4:0] OPC_COND = 5'b11100;
  localparam logic [4:0] OPC_JUMP = 5'b11010;
  localparam logic [4:0] OPC_CALL = 5'b11011;

endpackage

// File: rtl/relbr_decode.sv
module relbr_decode
  import relbr_pkg::*;
#(
  parameter int PC_W    = 21,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 11
) (
  input  logic [15:0]     instr,
  output br_kind_e        kind,
  output logic [2:0]      cond_sel,
  output logic [PC_W-1:0] off_ext
);
  localparam int SHORT_PAD = PC_W - SHORT_W;
  localparam int LONG_PAD  = PC_W - LONG_W;

  logic [PC_W-1:0] short_ext;
  logic [PC_W-1:0] long_ext;

  assign short_ext = {{SHORT_PAD{instr[SHORT_W-1]}}, instr[SHORT_W-1:0]};
  assign long_ext  = {{LONG_PAD{instr[LONG_W-1]}}, instr[LONG_W-1:0]};
  assign cond_sel  = instr[10:8];

  always_comb begin
    unique case (instr[15:11])
      OPC_COND: kind = KIND_COND;
      OPC_JUMP: kind = KIND_JUMP;
      OPC_CALL: kind = KIND_CALL;
      default:  kind = KIND_NONE;
    endcase
  end

  assign off_ext = (kind == KIND_COND) ? short_ext : long_ext;

endmodule

// File: rtl/relbr_cond.sv
module relbr_cond
  import relbr_pkg::*;
(
  input  logic [2:0] cond_sel,
  input  br_flags_t  flags,
  output logic       hit
);
  logic flag_bit;

  always_comb begin
    unique case (cond_sel[2:1])
      2'd0:    flag_bit = flags.z;
      2'd1:    flag_bit = flags.c;
      2'd2:    flag_bit = flags.ov;
      default: flag_bit = flags.n;
    endcase
  end

  // low select bit inverts the test
  assign hit = flag_bit ^ cond_sel[0];

endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
  parameter int PC_W = 21
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] off_ext,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] br_pc
);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

  assign seq_pc = pc + INSN_BYTES;
  assign br_pc  = seq_pc + {off_ext[PC_W-2:0], 1'b0};

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
  import relbr_pkg::*;
#(
  parameter int PC_W    = 21,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [15:0]     instr,
  input  logic [PC_W-1:0] pc,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_ov,
  input  logic            flag_n,
  output logic            out_valid,
  output logic            is_branch,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic [1:0]      cycles,
  output logic            push_req,
  output logic [PC_W-1:0] push_addr
);
  br_kind_e        kind;
  logic [2:0]      cond_sel;
  logic [PC_W-1:0] off_ext;
  logic            cond_hit;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] br_pc;
  br_flags_t       flags;

  assign flags = '{n: flag_n, ov: flag_ov, c: flag_c, z: flag_z};

  relbr_decode #(.PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_decode (
    .instr    (instr),
    .kind     (kind),
    .cond_sel (cond_sel),
    .off_ext  (off_ext)
  );

  relbr_cond u_cond (
    .cond_sel (cond_sel),
    .flags    (flags),
    .hit      (cond_hit)
  );

  relbr_target #(.PC_W(PC_W)) u_target (
    .pc      (pc),
    .off_ext (off_ext),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc)
  );

  // next-state
  logic            take_d;
  logic            branch_d;
  logic [PC_W-1:0] next_pc_d;
  logic [1:0]      cycles_d;
  logic            push_d;

  always_comb begin
    branch_d  = (kind != KIND_NONE);
    take_d    = (kind == KIND_JUMP) || (kind == KIND_CALL) ||
                ((kind == KIND_COND) && cond_hit);
    next_pc_d = take_d ? br_pc : seq_pc;
    cycles_d  = take_d ? 2'd2 : 2'd1;
    push_d    = (kind == KIND_CALL);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      push_req  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && take_d;
      push_req  <= in_valid && push_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_branch <= 1'b0;
      next_pc   <= '0;
      cycles    <= 2'd0;
      push_addr <= '0;
    end else if (in_valid) begin
      is_branch <= branch_d;
      next_pc   <= next_pc_d;
      cycles    <= cycles_d;
      push_addr <= seq_pc;
    end
  end

  // assertions
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !taken && !push_req);
  p_taken_two_cycles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> out_valid && is_branch && cycles == 2'd2);
  p_fallthrough_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !taken |-> cycles == 2'd1);
  p_jump_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && kind == KIND_JUMP |=> taken && !push_req);
  p_call_pushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> taken && next_pc != push_addr + PC_W'(2) || taken);
  p_call_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && kind == KIND_CALL |=> push_req && push_addr == $past(pc) + PC_W'(2));
  p_nonbranch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !is_branch |-> !taken && !push_req);

endmodule

// File: tb/relbr_unit_bench.sv
module relbr_unit_bench;
  localparam int PC_W = 21;
  localparam int NVEC = 12;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [15:0]     instr;
  logic [PC_W-1:0] pc;
  logic            flag_z, flag_c, flag_ov, flag_n;
  logic            out_valid, is_branch, taken, push_req;
  logic [PC_W-1:0] next_pc, push_addr;
  logic [1:0]      cycles;

  int n_chk;
  int n_bad;

  relbr_unit #(.PC_W(PC_W)) u_relbr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .flag_z(flag_z), .flag_c(flag_c), .flag_ov(flag_ov), .flag_n(flag_n),
    .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
    .next_pc(next_pc), .cycles(cycles), .push_req(push_req), .push_addr(push_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // entry: instr(16) pc(21) flags{n,ov,c,z}(4) exp_taken(1) exp_next(21) exp_push(1)
  localparam logic [63:0] VEC [NVEC] = '{
    {16'hE005, 21'h000100, 4'b0001, 1'b1, 21'h00010C, 1'b0}, // R3 R4 BZ taken
    {16'hE07F, 21'h000100, 4'b1110, 1'b0, 21'h000102, 1'b0}, // R5 BZ not taken
    {16'hE17F, 21'h000100, 4'b0000, 1'b1, 21'h000200, 1'b0}, // R4 max positive
    {16'hE280, 21'h000400, 4'b0010, 1'b1, 21'h000302, 1'b0}, // R4 max negative
    {16'hD3FF, 21'h001000, 4'b0000, 1'b1, 21'h001800, 1'b0}, // R7 max positive
    {16'hD400, 21'h001000, 4'b1111, 1'b1, 21'h000802, 1'b0}, // R7 max negative
    {16'hD801, 21'h002000, 4'b0000, 1'b1, 21'h002004, 1'b1}, // R8 call forward
    {16'hDFFF, 21'h002000, 4'b1111, 1'b1, 21'h002000, 1'b1}, // R8 call back
    {16'h0000, 21'h000030, 4'b1111, 1'b0, 21'h000032, 1'b0}, // R9 nop
    {16'hE800, 21'h000040, 4'b1111, 1'b0, 21'h000042, 1'b0}, // R9 1110 1xxx
    {16'hD3FF, 21'h1FFFFE, 4'b0000, 1'b1, 21'h0007FE, 1'b0}, // R10 wrap up
    {16'hD400, 21'h000000, 4'b0000, 1'b1, 21'h1FF802, 1'b0}  // R10 wrap down
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic [PC_W-1:0] a,
                       input logic [3:0] f);
    @(negedge clk);
    instr    = w;
    pc       = a;
    {flag_n, flag_ov, flag_c, flag_z} = f;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    instr = '0;
    pc = '0;
    {flag_n, flag_ov, flag_c, flag_z} = 4'b0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 0);
    chk("R1", "next_pc in reset", 32'(next_pc), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 0);
    chk("R1", "taken after reset", 32'(taken), 0);
    chk("R1", "push_req after reset", 32'(push_req), 0);
    chk("R1", "cycles after reset", 32'(cycles), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      issue(v[63:48], v[47:27], v[26:23]);
      chk("R2", "out_valid", 32'(out_valid), 1);
      chk("R6", "taken", 32'(taken), 32'(v[22]));
      chk("R4", "next_pc", 32'(next_pc), 32'(v[21:1]));
      chk("R6", "cycles", 32'(cycles), v[22] ? 2 : 1);
      chk("R8", "push_req", 32'(push_req), 32'(v[0]));
      if (v[0]) chk("R8", "push_addr", 32'(push_addr), 32'(v[47:27] + 21'd2));
      chk("R9", "is_branch", 32'(is_branch),
          (v[63:59] == 5'b11100 || v[63:59] == 5'b11010 || v[63:59] == 5'b11011) ? 1 : 0);
    end

    // R3: every condition, selected flag both ways, other flags opposite
    for (int c = 0; c < 8; c++) begin
      for (int fv = 0; fv < 2; fv++) begin
        logic [3:0] f;
        logic       exp_t;
        f = fv[0] ? 4'b0000 : 4'b1111;
        f[c / 2] = fv[0];
        exp_t = c[0] ? ~fv[0] : fv[0];
        issue({5'b11100, c[2:0], 8'h10}, 21'h000100, f);
        chk("R3", "cond taken", 32'(taken), 32'(exp_t));
        chk("R3", "cond next_pc", 32'(next_pc), exp_t ? 32'h122 : 32'h102);
      end
    end

    // R2: idle cycle drops valid
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "taken idle", 32'(taken), 0);

    // R9: 11110 and 11111 groups ignored
    issue(16'hF3FF, 21'h000500, 4'b1111);
    chk("R9", "11110 taken", 32'(taken), 0);
    chk("R9", "11110 next_pc", 32'(next_pc), 32'h502);
    issue(16'hFFFF, 21'h000500, 4'b0000);
    chk("R9", "11111 push", 32'(push_req), 0);
    chk("R9", "11111 cycles", 32'(cycles), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule